// File: doc/BRIEF.md
# Indexed Interrupt Routing Register Window

This block holds the configuration state of an I/O interrupt routing controller and makes it reachable through a narrow two-register window. Software first writes an internal register index into a select register, then reads or writes the chosen register through a separate data port. Behind the window sit a controller identifier, a read-only version word, an arbitration identifier and a table of 64-bit routing entries, one per interrupt input. Each entry is reached as two 32-bit halves.

The routing logic next to this block takes every table entry, the controller identifier and the arbitration identifier straight from output ports. Each table entry holds a vector in bits 7:0, a delivery mode in bits 10:8, a destination mode in bit 11, a polarity in bit 13, a trigger mode in bit 15, a mask in bit 16 and a destination in bits 63:56. The bus port is a simple valid/write/address/data interface. Its read data and error flag are combinational in the same cycle, and writes take effect at the clock edge. The reset identifier parameter must stay below 0xFF, because that value is reserved to mean broadcast.

Top module: `irq_route_regs`

## Requirements
- R1: Bus offset 0 reads and writes the full 32-bit select register. The select register is zero after reset.
- R2: Bus offset 16 accesses the internal register whose index is the select register's bits 7:0. Select bits 31:8 do not take part in the decode.
- R3: Index 0 is the controller ID. A write stores data bits 31:24. A read returns the ID in bits 31:24 with zeros elsewhere. The ID is RESET_ID after reset and is driven on `ctrl_id`.
- R4: Index 1 reads ((ENTRIES-1) << 16) | VERSION, which is 0x00170011 with the defaults. Writes to index 1 change nothing.
- R5: Index 2 is the arbitration ID. It has the same read and write format as index 0 and is driven on `arb_id`. After reset it equals RESET_ID.
- R6: Indices 0x10 to 0x10+2*ENTRIES-1 reach entry (index-0x10)/2. An even index selects the low word and an odd index selects the high word. Entry n appears on `entries[64*n +: 64]`.
- R7: A write to a table half clears its reserved bits. The low half keeps only the bits in mask 0x0001AFFF, and the high half keeps only the bits in mask 0xFF000000.
- R8: After reset every table entry reads 0x00000000_00010000, which means only the mask bit is set.
- R9: Indices 3 to 0x0F and indices 0x10+2*ENTRIES to 0xFF read as zero, and writes to them change no state.
- R10: A valid access at any offset other than 0 or 16 raises `bus_err`, returns zero read data and changes no state. Accesses at offsets 0 and 16 leave `bus_err` low.
- R11: Read data is valid in the same cycle as the request. A write becomes visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | Illegal offset response |
| ctrl_id | output | 8 | Current controller ID |
| arb_id | output | 8 | Current arbitration ID |
| entries | output | 64*ENTRIES | All routing entries, entry n at bits 64*n+63:64*n |

## Verification
The assertions assume that all accesses are 32 bits wide. They also assume that bus inputs are stable around the clock edge and that software only changes the select register through offset 0. On that basis they check that identifiers and table words move only on the matching data-port writes, and that reserved bits never become nonzero. The stimulus always sets the select register with its own write before it touches the data port. It drives every input at the falling edge and holds it across the next rising edge, so the assumptions hold.

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
  parameter int          ENTRIES  = 24,
  parameter int          ADDR_W   = 5,
  parameter logic [7:0]  VERSION  = 8'h11,
  parameter logic [7:0]  RESET_ID = 8'h05
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    bus_err,
  output logic [7:0]              ctrl_id,
  output logic [7:0]              arb_id,
  output logic [64*ENTRIES-1:0]   entries
);
  localparam int          EW       = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int          TAB_LO   = 16;
  localparam int          TAB_HI   = TAB_LO + 2*ENTRIES;
  localparam logic [31:0] LO_KEEP  = 32'h0001_AFFF;
  localparam logic [31:0] HI_KEEP  = 32'hFF00_0000;
  localparam logic [31:0] LO_RST   = 32'h0001_0000;
  localparam logic [7:0]  MAX_IDX  = 8'(ENTRIES - 1);

  logic [31:0] sel_q;
  logic [7:0]  id_q, arb_q;
  logic [31:0] lo_q [ENTRIES];
  logic [31:0] hi_q [ENTRIES];

  logic [7:0]    idx;
  logic [7:0]    rel;
  logic [EW-1:0] ent;
  logic          in_tab;
  logic          at_sel, at_dat, sel_wr, dat_wr, tab_wr;
  logic [31:0]   reg_rd;

  assign idx    = sel_q[7:0];
  assign rel    = idx - 8'(TAB_LO);
  assign ent    = rel[EW:1];
  assign in_tab = (int'(idx) >= TAB_LO) && (int'(idx) < TAB_HI);

  assign at_sel = bus_addr == ADDR_W'(0);
  assign at_dat = bus_addr == ADDR_W'(16);
  assign sel_wr = bus_valid && bus_write && at_sel;
  assign dat_wr = bus_valid && bus_write && at_dat;
  assign tab_wr = dat_wr && in_tab;

  always_comb begin
    reg_rd = '0;
    case (idx)
      8'h00:   reg_rd = {id_q, 24'h0};
      8'h01:   reg_rd = {8'h00, MAX_IDX, 8'h00, VERSION};
      8'h02:   reg_rd = {arb_q, 24'h0};
      default: if (in_tab) reg_rd = idx[0] ? hi_q[ent] : lo_q[ent];
    endcase
  end

  assign bus_err   = bus_valid && !at_sel && !at_dat;
  assign bus_rdata = (!bus_valid || bus_write) ? 32'h0 :
                     at_sel ? sel_q :
                     at_dat ? reg_rd : 32'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= RESET_ID;
      arb_q <= RESET_ID;
    end else begin
      if (sel_wr)                 sel_q <= bus_wdata;
      if (dat_wr && idx == 8'h00) id_q  <= bus_wdata[31:24];
      if (dat_wr && idx == 8'h02) arb_q <= bus_wdata[31:24];
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[i] <= LO_RST;
        hi_q[i] <= '0;
      end else if (tab_wr && ent == EW'(i)) begin
        if (idx[0]) hi_q[i] <= bus_wdata & HI_KEEP;
        else        lo_q[i] <= bus_wdata & LO_KEEP;
      end
    end
    assign entries[64*i +: 64] = {hi_q[i], lo_q[i]};
  end

  assign ctrl_id = id_q;
  assign arb_id  = arb_q;
endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
  parameter int ENTRIES = 24,
  parameter int ADDR_W  = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_valid,
  input logic                  bus_write,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_err,
  input logic [7:0]            sel_idx,
  input logic [7:0]            ctrl_id,
  input logic [7:0]            arb_id,
  input logic [64*ENTRIES-1:0] entries
);
  localparam logic [31:0] LO_KEEP = 32'h0001_AFFF;
  localparam logic [31:0] HI_KEEP = 32'hFF00_0000;

  logic rsv_bad;
  always_comb begin
    rsv_bad = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if ((entries[64*i +: 32] & ~LO_KEEP) != 32'h0)      rsv_bad = 1'b1;
      if ((entries[64*i+32 +: 32] & ~HI_KEEP) != 32'h0)   rsv_bad = 1'b1;
    end
  end

  logic dat_wr;
  assign dat_wr = bus_valid && bus_write && bus_addr == ADDR_W'(16);

  p_rsv_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rsv_bad);

  p_id_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_wr && sel_idx == 8'h00) |=> $stable(ctrl_id));

  p_arb_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_wr && sel_idx == 8'h02) |=> $stable(arb_id));

  p_ver_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && sel_idx == 8'h01) |=> $stable(entries) && $stable(ctrl_id) && $stable(arb_id));

  p_err_nochg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> $stable(entries) && $stable(ctrl_id) && $stable(arb_id));

  p_undef_nochg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && sel_idx >= 8'h03 && sel_idx < 8'h10) |=> $stable(entries));
endmodule

bind irq_route_regs irq_route_regs_chk #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_err(bus_err), .sel_idx(sel_q[7:0]),
  .ctrl_id(ctrl_id), .arb_id(arb_id), .entries(entries)
);

// File: tb/sim_irq_route_regs.sv
`timescale 1ns/1ps
module sim_irq_route_regs;
  localparam int NE = 24;
  localparam int N  = 38;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_valid = 1'b0, bus_write = 1'b0;
  logic [4:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            bus_err;
  logic [7:0]      ctrl_id, arb_id;
  logic [64*NE-1:0] entries;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  irq_route_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .ctrl_id(ctrl_id), .arb_id(arb_id), .entries(entries)
  );

  // {write, addr, wdata, expected rdata, expected err}
  localparam logic [70:0] V [N] = '{
    {1'b1, 5'd0,  32'h0000_0000, 32'h0,          1'b0}, // R1 sel=0
    {1'b1, 5'd16, 32'hAB12_3456, 32'h0,          1'b0}, // R3
    {1'b0, 5'd16, 32'h0,         32'hAB00_0000,  1'b0}, // R3
    {1'b1, 5'd0,  32'h0000_0001, 32'h0,          1'b0},
    {1'b0, 5'd16, 32'h0,         32'h0017_0011,  1'b0}, // R4
    {1'b1, 5'd16, 32'hFFFF_FFFF, 32'h0,          1'b0},
    {1'b0, 5'd16, 32'h0,         32'h0017_0011,  1'b0}, // R4 write ignored
    {1'b1, 5'd0,  32'h0000_0002, 32'h0,          1'b0},
    {1'b0, 5'd16, 32'h0,         32'h0500_0000,  1'b0}, // R5 reset value
    {1'b1, 5'd16, 32'h3C00_FFFF, 32'h0,          1'b0},
    {1'b0, 5'd16, 32'h0,         32'h3C00_0000,  1'b0}, // R5
    {1'b1, 5'd0,  32'h0000_0010, 32'h0,          1'b0},
    {1'b0, 5'd16, 32'h0,         32'h0001_0000,  1'b0}, // R8
    {1'b1, 5'd16, 32'hFFFF_FFFF, 32'h0,          1'b0},
    {1'b0, 5'd16, 32'h0,         32'h0001_AFFF,  1'b0}, // R7 low
    {1'b1, 5'd0,  32'h0000_0011, 32'h0,          1'b0},
    {1'b1, 5'd16, 32'hFFFF_FFFF, 32'h0,          1'b0},
    {1'b0, 5'd16, 32'h0,         32'hFF00_0000,  1'b0}, // R7 high
    {1'b1, 5'd0,  32'h0000_003F, 32'h0,          1'b0},
    {1'b1, 5'd16, 32'h1234_5678, 32'h0,          1'b0},
    {1'b0, 5'd16, 32'h0,         32'h1200_0000,  1'b0}, // R6 last high
    {1'b1, 5'd0,  32'h0000_003E, 32'h0,          1'b0},
    {1'b0, 5'd16, 32'h0,         32'h0001_0000,  1'b0}, // R6 last low
    {1'b1, 5'd0,  32'h0000_0040, 32'h0,          1'b0},
    {1'b1, 5'd16, 32'hDEAD_BEEF, 32'h0,          1'b0},
    {1'b0, 5'd16, 32'h0,         32'h0,          1'b0}, // R9 past table
    {1'b1, 5'd0,  32'h0000_0003, 32'h0,          1'b0},
    {1'b1, 5'd16, 32'hFFFF_FFFF, 32'h0,          1'b0},
    {1'b0, 5'd16, 32'h0,         32'h0,          1'b0}, // R9 gap
    {1'b1, 5'd0,  32'h0000_000F, 32'h0,          1'b0},
    {1'b0, 5'd16, 32'h0,         32'h0,          1'b0}, // R9
    {1'b0, 5'd0,  32'h0,         32'h0000_000F,  1'b0}, // R1 readback
    {1'b1, 5'd0,  32'hFFFF_FF00, 32'h0,          1'b0},
    {1'b0, 5'd0,  32'h0,         32'hFFFF_FF00,  1'b0}, // R1 full width
    {1'b0, 5'd16, 32'h0,         32'hAB00_0000,  1'b0}, // R2 upper bits ignored
    {1'b0, 5'd4,  32'h0,         32'h0,          1'b1}, // R10
    {1'b1, 5'd8,  32'h1111_1111, 32'h0,          1'b1}, // R10
    {1'b0, 5'd0,  32'h0,         32'hFFFF_FF00,  1'b0}  // R10 sel untouched
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    chk("R3 reset id", 64'(ctrl_id), 64'h05);
    chk("R5 reset arb", 64'(arb_id), 64'h05);
    for (int i = 0; i < NE; i++)
      chk("R8 reset entry", entries[64*i +: 64], 64'h0000_0000_0001_0000);
    acc(1'b0, 5'd0, 32'h0);
    chk("R1 reset sel", 64'(bus_rdata), 64'h0);
    chk("R11 same-cycle err low", 64'(bus_err), 64'h0);

    for (int k = 0; k < N; k++) begin
      acc(V[k][70], V[k][69:65], V[k][64:33]);
      chk("R11 err", 64'(bus_err), 64'(V[k][0]));
      if (!V[k][70]) chk("R2 read", 64'(bus_rdata), 64'(V[k][32:1]));
    end
    idle();

    chk("R6 entry0 port", entries[0 +: 64], 64'hFF00_0000_0001_AFFF);
    chk("R6 entry23 port", entries[64*23 +: 64], 64'h1200_0000_0001_0000);
    chk("R6 entry1 untouched", entries[64 +: 64], 64'h0000_0000_0001_0000);
    chk("R3 id port", 64'(ctrl_id), 64'hAB);
    chk("R5 arb port", 64'(arb_id), 64'h3C);

    acc(1'b1, 5'd20, 32'h7700_0000);
    chk("R10 err", 64'(bus_err), 64'h1);
    idle();
    chk("R10 no id change", 64'(ctrl_id), 64'hAB);

    acc(1'b1, 5'd16, 32'h9900_0000);
    idle();
    chk("R11 write visible next", 64'(ctrl_id), 64'h99);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule